// File: doc/BRIEF.md
# Bounded Directory Entry Controller

This block is the coherence state machine for one entry of a sparse, distributed directory whose capacity is smaller than the combined capacity of the private caches it serves. For its block it records the coherence state, a sharer bit-vector over `NC` caches, the current owner and a pending requester. It accepts GetS, GetM, PutS and PutM from the caches. It also accepts a replacement event that the directory raises when it needs the entry for another block, a data-arrival strobe, and the write-acknowledge from the memory controller. It emits forwarded requests, invalidations and recalls on a multicast forward port. Data, put-acknowledge and writeback messages go out on a response port.

Besides the usual invalid, shared and modified states, the entry has a non-cached state. In that state the last-level cache holds the current value and the directory keeps nothing. Evicting a shared or modified entry first writes the value back to the last-level cache. The entry then holds every new GetS, GetM and replacement until the memory controller acknowledges that write, so that no reader can fetch a stale copy. Put requests are still answered while the entry waits, and also in the non-cached state, so that no cache is left waiting for an acknowledge. The response port carries one message per cycle. When a single event produces two responses, the second goes into a small queue and is sent on the next cycle, and the request input is held off until the queue has drained.

Top module: `dir_entry_fsm`

## Requirements
- R1: After reset, `fwd_valid` and `rsp_valid` are low, `req_ready` is high, and the entry is non-cached: a first GetS is forwarded to memory.
- R2: Request codes are GetS=0, GetM=1, PutS=2, PutM=3, Replace=4. A GetS in the non-cached state produces, one cycle later, a forward of kind 0 (read) with `fwd_mc`=1, an empty `fwd_mask` and `fwd_req` set to the requester. `req_ready` stays low until the data strobe arrives. One cycle after the strobe, a response of kind 0 (Data) goes to the requester with an ack count of 0, and the entry becomes shared.
- R3: A GetM in the shared state answers with Data, whose `rsp_acks` is the number of sharers other than the requester. In the same cycle it sends a forward of kind 2 (invalidate) whose mask is exactly those sharers; when there are none, no forward is sent. The requester becomes the owner in the modified state.
- R4: A Replace in the modified state sends a forward of kind 3 (recall) with the owner's bit alone in the mask. Until `mc_ack`, GetS, GetM and Replace see `req_ready` low. After `mc_ack` the entry is non-cached.
- R5: A Replace in the shared state sends a response of kind 2 (WB) to destination `NC` (the memory controller) and a recall to every sharer. It then holds requests as in R4 until `mc_ack`, which makes the entry non-cached.
- R6: In the non-cached state, a PutS or PutM is answered one cycle later with a response of kind 1 (put-acknowledge) to the sender. A Replace in that state is accepted and produces no message.
- R7: While the entry waits for `mc_ack` after a recall, a PutM from the owner is answered with a put-acknowledge one cycle later and a WB to the memory controller on the following cycle. `req_ready` is low on the cycle in between. PutS and PutM are accepted while waiting.
- R8: A GetS in the modified state forwards a read (kind 0) to the owner, with `fwd_req` naming the requester. On the data strobe the entry becomes shared, with the old owner and the requester as sharers.
- R9: A PutS that removes the last sharer leaves the entry invalid. A GetS or GetM in the invalid state is answered directly with Data (ack count 0) and no forward.
- R10: A Replace in the invalid state sends WB to the memory controller and holds GetS, GetM and Replace until `mc_ack`.
- R11: A GetM in the modified state from another cache forwards a write request (kind 1) to the owner and makes the requester the owner. A PutM from the owner is acknowledged and leaves the entry invalid.
- R12: A GetM in the non-cached state forwards a write request (kind 1) to memory. On the data strobe it answers the requester with Data (ack count 0), and the entry becomes modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 3 | Request code (GetS, GetM, PutS, PutM, Replace) |
| req_src | input | $clog2(NC+1) | Requesting cache index |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| data_valid | input | 1 | Data for the pending fill has arrived |
| mc_ack | input | 1 | Memory controller finished the writeback |
| fwd_valid | output | 1 | Forward message valid |
| fwd_kind | output | 2 | Read, write, invalidate or recall |
| fwd_mask | output | NC | Cache destinations of the forward |
| fwd_mc | output | 1 | Forward goes to the memory controller |
| fwd_req | output | $clog2(NC+1) | Requester named in the forward |
| rsp_valid | output | 1 | Response message valid |
| rsp_kind | output | 2 | Data, put-acknowledge or WB |
| rsp_dst | output | $clog2(NC+1) | Destination; `NC` means the memory controller |
| rsp_acks | output | $clog2(NC+1) | Invalidation acks the receiver must expect |

## Verification
The assertions assume that `req_src` always names a real cache, below `NC`, and that a request, once raised, stays steady until it is accepted. They assume that `data_valid` arrives only while a fill is pending and that `mc_ack` comes only while the entry waits for it. They also assume that a cache never asks for a block it already owns. The stimulus comes from tasks that hold each request until `req_ready` takes it, raise the data strobe only after a forward to memory or to the owner, and pulse `mc_ack` only after a replacement. Each owner-side scenario uses a requester that differs from the current owner.

// File: rtl/dir_entry_fsm.sv
module dir_entry_fsm #(
  parameter int NC = 4,
  parameter int FIFO_DEPTH = 2,
  localparam int IDW = $clog2(NC + 1),
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [2:0]     req_kind,
  input  logic [IDW-1:0] req_src,
  output logic           req_ready,
  input  logic           data_valid,
  input  logic           mc_ack,
  output logic           fwd_valid,
  output logic [1:0]     fwd_kind,
  output logic [NC-1:0]  fwd_mask,
  output logic           fwd_mc,
  output logic [IDW-1:0] fwd_req,
  output logic           rsp_valid,
  output logic [1:0]     rsp_kind,
  output logic [IDW-1:0] rsp_dst,
  output logic [IDW-1:0] rsp_acks
);

  localparam logic [2:0] K_GETS = 3'd0, K_GETM = 3'd1, K_PUTS = 3'd2, K_PUTM = 3'd3, K_REPL = 3'd4;
  localparam logic [1:0] F_RD = 2'd0, F_WR = 2'd1, F_INV = 2'd2, F_RCL = 2'd3;
  localparam logic [1:0] R_DATA = 2'd0, R_PACK = 2'd1, R_WB = 2'd2;
  localparam logic [IDW-1:0] MC_ID = IDW'(NC);

  typedef enum logic [3:0] {
    ST_N = 4'd0, ST_I = 4'd1, ST_S = 4'd2, ST_M = 4'd3,
    ST_NSD = 4'd4, ST_NMD = 4'd5, ST_MSD = 4'd6, ST_RCA = 4'd7, ST_WBA = 4'd8
  } st_t;

  st_t st, n_st;
  logic [NC-1:0]  sh, n_sh, src_oh, own_oh, pend_oh, others;
  logic [IDW-1:0] own, n_own, pend, n_pend, n_others;
  logic           is_put, stable, waiting, acc, push, pop;
  logic [CW-1:0]  q_cnt, wr_idx;
  logic [1:0]     q_kind [FIFO_DEPTH];
  logic [IDW-1:0] q_dst  [FIFO_DEPTH];

  logic           f_v, f_mc, r0_v, r1_v;
  logic [1:0]     f_k, r0_k;
  logic [NC-1:0]  f_m;
  logic [IDW-1:0] f_q, r0_d, r0_a;

  assign src_oh  = NC'(1) << req_src;
  assign own_oh  = NC'(1) << own;
  assign pend_oh = NC'(1) << pend;
  assign others  = sh & ~src_oh;
  assign is_put  = (req_kind == K_PUTS) || (req_kind == K_PUTM);
  assign stable  = st inside {ST_N, ST_I, ST_S, ST_M};
  assign waiting = st inside {ST_RCA, ST_WBA};
  assign req_ready = (q_cnt == '0) && (stable || (waiting && is_put));
  assign acc     = req_valid && req_ready;
  assign push    = r1_v;
  assign pop     = q_cnt != '0;
  assign wr_idx  = q_cnt - CW'(pop);

  always_comb begin
    n_others = '0;
    for (int i = 0; i < NC; i++) n_others = n_others + IDW'(others[i]);
  end

  always_comb begin
    n_st = st; n_sh = sh; n_own = own; n_pend = pend;
    f_v = 1'b0; f_k = '0; f_m = '0; f_mc = 1'b0; f_q = '0;
    r0_v = 1'b0; r0_k = '0; r0_d = '0; r0_a = '0;
    r1_v = 1'b0;
    case (st)
      ST_N: if (acc) begin
        if (req_kind == K_GETS) begin
          n_sh = src_oh; n_pend = req_src; n_st = ST_NSD;
          f_v = 1'b1; f_k = F_RD; f_mc = 1'b1; f_q = req_src;
        end else if (req_kind == K_GETM) begin
          n_own = req_src; n_st = ST_NMD;
          f_v = 1'b1; f_k = F_WR; f_mc = 1'b1; f_q = req_src;
        end else if (is_put) begin
          r0_v = 1'b1; r0_k = R_PACK; r0_d = req_src;
        end
      end
      ST_I: if (acc) begin
        if (req_kind == K_GETS) begin
          r0_v = 1'b1; r0_k = R_DATA; r0_d = req_src;
          n_sh = src_oh; n_st = ST_S;
        end else if (req_kind == K_GETM) begin
          r0_v = 1'b1; r0_k = R_DATA; r0_d = req_src;
          n_own = req_src; n_st = ST_M;
        end else if (is_put) begin
          r0_v = 1'b1; r0_k = R_PACK; r0_d = req_src;
        end else if (req_kind == K_REPL) begin
          r0_v = 1'b1; r0_k = R_WB; r0_d = MC_ID; n_st = ST_WBA;
        end
      end
      ST_S: if (acc) begin
        if (req_kind == K_GETS) begin
          r0_v = 1'b1; r0_k = R_DATA; r0_d = req_src;
          n_sh = sh | src_oh;
        end else if (req_kind == K_GETM) begin
          r0_v = 1'b1; r0_k = R_DATA; r0_d = req_src; r0_a = n_others;
          if (others != '0) begin
            f_v = 1'b1; f_k = F_INV; f_m = others; f_q = req_src;
          end
          n_sh = '0; n_own = req_src; n_st = ST_M;
        end else if (is_put) begin
          r0_v = 1'b1; r0_k = R_PACK; r0_d = req_src;
          n_sh = others;
          if (others == '0) n_st = ST_I;
        end else if (req_kind == K_REPL) begin
          r0_v = 1'b1; r0_k = R_WB; r0_d = MC_ID;
          if (sh != '0) begin
            f_v = 1'b1; f_k = F_RCL; f_m = sh;
          end
          n_sh = '0; n_st = ST_WBA;
        end
      end
      ST_M: if (acc) begin
        if (req_kind == K_GETS) begin
          f_v = 1'b1; f_k = F_RD; f_m = own_oh; f_q = req_src;
          n_pend = req_src; n_st = ST_MSD;
        end else if (req_kind == K_GETM) begin
          f_v = 1'b1; f_k = F_WR; f_m = own_oh; f_q = req_src;
          n_own = req_src;
        end else if (is_put) begin
          r0_v = 1'b1; r0_k = R_PACK; r0_d = req_src;
          if (req_kind == K_PUTM && req_src == own) begin
            n_sh = '0; n_st = ST_I;
          end
        end else if (req_kind == K_REPL) begin
          f_v = 1'b1; f_k = F_RCL; f_m = own_oh;
          n_st = ST_RCA;
        end
      end
      ST_RCA, ST_WBA: begin
        if (acc) begin
          r0_v = 1'b1; r0_k = R_PACK; r0_d = req_src;
          if (st == ST_RCA && req_kind == K_PUTM && req_src == own) r1_v = 1'b1;
        end
        if (mc_ack) n_st = ST_N;
      end
      ST_NSD: if (data_valid) begin
        r0_v = 1'b1; r0_k = R_DATA; r0_d = pend; n_st = ST_S;
      end
      ST_NMD: if (data_valid) begin
        r0_v = 1'b1; r0_k = R_DATA; r0_d = own; n_st = ST_M;
      end
      ST_MSD: if (data_valid) begin
        n_sh = own_oh | pend_oh; n_st = ST_S;
      end
      default: n_st = ST_N;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_N; sh <= '0; own <= '0; pend <= '0; q_cnt <= '0;
      fwd_valid <= 1'b0; fwd_kind <= '0; fwd_mask <= '0; fwd_mc <= 1'b0; fwd_req <= '0;
      rsp_valid <= 1'b0; rsp_kind <= '0; rsp_dst <= '0; rsp_acks <= '0;
    end else begin
      st <= n_st; sh <= n_sh; own <= n_own; pend <= n_pend;
      q_cnt <= q_cnt + CW'(push) - CW'(pop);
      fwd_valid <= f_v; fwd_kind <= f_k; fwd_mask <= f_m; fwd_mc <= f_mc; fwd_req <= f_q;
      if (pop) begin
        rsp_valid <= 1'b1; rsp_kind <= q_kind[0]; rsp_dst <= q_dst[0]; rsp_acks <= '0;
      end else begin
        rsp_valid <= r0_v; rsp_kind <= r0_k; rsp_dst <= r0_d; rsp_acks <= r0_a;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pop)
      for (int i = 0; i < FIFO_DEPTH - 1; i++) begin
        q_kind[i] <= q_kind[i+1];
        q_dst[i]  <= q_dst[i+1];
      end
    if (push)
      for (int i = 0; i < FIFO_DEPTH; i++)
        if (i == int'(wr_idx)) begin
          q_kind[i] <= R_WB;
          q_dst[i]  <= MC_ID;
        end
  end

endmodule

// File: rtl/dir_entry_chk.sv
module dir_entry_chk #(
  parameter int NC = 4,
  parameter int FIFO_DEPTH = 2,
  localparam int IDW = $clog2(NC + 1),
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic [2:0]     req_kind,
  input logic [IDW-1:0] req_src,
  input logic           req_ready,
  input logic           fwd_valid,
  input logic [1:0]     fwd_kind,
  input logic [NC-1:0]  fwd_mask,
  input logic           fwd_mc,
  input logic           rsp_valid,
  input logic [1:0]     rsp_kind,
  input logic [IDW-1:0] rsp_dst,
  input logic [IDW-1:0] rsp_acks,
  input logic [3:0]     st_code,
  input logic [CW-1:0]  q_cnt,
  input logic           push
);

  // R7
  fifo_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (q_cnt < CW'(FIFO_DEPTH)));

  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt != '0) |-> !req_ready);

  // R4
  ack_wait_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_code == 4'd7 || st_code == 4'd8) && req_valid && req_kind != 3'd2 && req_kind != 3'd3)
    |-> !req_ready);

  // R6
  noncached_putack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_code == 4'd0 && req_valid && req_ready && (req_kind == 3'd2 || req_kind == 3'd3))
    |=> (rsp_valid && rsp_kind == 2'd1 && rsp_dst == $past(req_src)));

  // R3
  inv_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_kind == 2'd2)
    |-> (rsp_valid && rsp_kind == 2'd0 && !fwd_mc && rsp_acks == IDW'($countones(fwd_mask))));

  // R2
  mem_fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && fwd_mc) |-> !req_ready);

endmodule

bind dir_entry_fsm dir_entry_chk #(.NC(NC), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_src(req_src), .req_ready(req_ready), .fwd_valid(fwd_valid),
  .fwd_kind(fwd_kind), .fwd_mask(fwd_mask), .fwd_mc(fwd_mc),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
  .rsp_acks(rsp_acks), .st_code(st), .q_cnt(q_cnt), .push(push)
);

// File: tb/dir_entry_fsm_test.sv
`timescale 1ns/100ps
module dir_entry_fsm_test;
  localparam int NC = 4;
  localparam int IDW = $clog2(NC + 1);
  localparam int MCID = NC;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, req_valid, data_valid, mc_ack, req_ready;
  logic [2:0] req_kind;
  logic [IDW-1:0] req_src;
  logic fwd_valid, fwd_mc, rsp_valid;
  logic [1:0] fwd_kind, rsp_kind;
  logic [NC-1:0] fwd_mask;
  logic [IDW-1:0] fwd_req, rsp_dst, rsp_acks;

  dir_entry_fsm #(.NC(NC), .FIFO_DEPTH(2)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_src(req_src), .req_ready(req_ready), .data_valid(data_valid), .mc_ack(mc_ack),
    .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_mask(fwd_mask), .fwd_mc(fwd_mc),
    .fwd_req(fwd_req), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
    .rsp_acks(rsp_acks)
  );

  int n_checks = 0, n_fail = 0;
  string tag = "R1";
  bit live = 0;

  // model: 0 N,1 I,2 S,3 M,4 fill-for-read,5 fill-for-write,6 owner-read,7 recall-wait,8 wb-wait
  int m_st, m_own, m_pend;
  logic [NC-1:0] m_sh;
  int rq[$];
  logic e_fv, e_fmc, e_rv;
  logic [1:0] e_fk, e_rk;
  logic [NC-1:0] e_fm;
  logic [IDW-1:0] e_fq, e_rd, e_ra;
  bit d_rv, d_dv, d_ack;
  int d_rk, d_rs;

  task automatic chk(string what, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic bit m_ready(int k);
    bit put = (k == 2 || k == 3);
    if (rq.size() > 0) return 0;
    return (m_st <= 3) || ((m_st == 7 || m_st == 8) && put);
  endfunction

  task automatic fwd(int k, logic [NC-1:0] m, bit mc, int q);
    e_fv = 1; e_fk = 2'(k); e_fm = m; e_fmc = mc; e_fq = IDW'(q);
  endtask

  function automatic int rsp(int k, int d, int a);
    return k * 256 + d * 16 + a;
  endfunction

  task automatic model_step(output bit took);
    logic [NC-1:0] me, oth;
    int cnt, code;
    int nr[$];
    bit put;
    took = d_rv && m_ready(d_rk);
    me = NC'(1) << d_rs;
    put = (d_rk == 2 || d_rk == 3);
    e_fv = 0; e_fk = 0; e_fm = 0; e_fmc = 0; e_fq = 0;
    case (m_st)
      0: if (took) begin
        if (d_rk == 0) begin m_sh = me; m_pend = d_rs; fwd(0, 0, 1, d_rs); m_st = 4; end
        else if (d_rk == 1) begin m_own = d_rs; fwd(1, 0, 1, d_rs); m_st = 5; end
        else if (put) nr.push_back(rsp(1, d_rs, 0));
      end
      1: if (took) begin
        if (d_rk == 0) begin nr.push_back(rsp(0, d_rs, 0)); m_sh = me; m_st = 2; end
        else if (d_rk == 1) begin nr.push_back(rsp(0, d_rs, 0)); m_own = d_rs; m_st = 3; end
        else if (put) nr.push_back(rsp(1, d_rs, 0));
        else if (d_rk == 4) begin nr.push_back(rsp(2, MCID, 0)); m_st = 8; end
      end
      2: if (took) begin
        oth = m_sh & ~me;
        cnt = 0;
        for (int i = 0; i < NC; i++) if (oth[i]) cnt++;
        if (d_rk == 0) begin nr.push_back(rsp(0, d_rs, 0)); m_sh = m_sh | me; end
        else if (d_rk == 1) begin
          nr.push_back(rsp(0, d_rs, cnt));
          if (oth != 0) fwd(2, oth, 0, d_rs);
          m_sh = 0; m_own = d_rs; m_st = 3;
        end else if (put) begin
          nr.push_back(rsp(1, d_rs, 0)); m_sh = oth;
          if (m_sh == 0) m_st = 1;
        end else if (d_rk == 4) begin
          nr.push_back(rsp(2, MCID, 0));
          if (m_sh != 0) fwd(3, m_sh, 0, 0);
          m_sh = 0; m_st = 8;
        end
      end
      3: if (took) begin
        if (d_rk == 0) begin fwd(0, NC'(1) << m_own, 0, d_rs); m_pend = d_rs; m_st = 6; end
        else if (d_rk == 1) begin fwd(1, NC'(1) << m_own, 0, d_rs); m_own = d_rs; end
        else if (put) begin
          nr.push_back(rsp(1, d_rs, 0));
          if (d_rk == 3 && d_rs == m_own) begin m_sh = 0; m_st = 1; end
        end else if (d_rk == 4) begin fwd(3, NC'(1) << m_own, 0, 0); m_st = 7; end
      end
      7, 8: begin
        if (took) begin
          nr.push_back(rsp(1, d_rs, 0));
          if (m_st == 7 && d_rk == 3 && d_rs == m_own) nr.push_back(rsp(2, MCID, 0));
        end
        if (d_ack) m_st = 0;
      end
      4: if (d_dv) begin nr.push_back(rsp(0, m_pend, 0)); m_st = 2; end
      5: if (d_dv) begin nr.push_back(rsp(0, m_own, 0)); m_st = 3; end
      6: if (d_dv) begin m_sh = (NC'(1) << m_own) | (NC'(1) << m_pend); m_st = 2; end
      default: ;
    endcase
    foreach (nr[i]) rq.push_back(nr[i]);
    if (rq.size() > 0) begin
      code = rq.pop_front();
      e_rv = 1; e_rk = 2'(code / 256); e_rd = IDW'((code / 16) % 16); e_ra = IDW'(code % 16);
    end else begin
      e_rv = 0; e_rk = 0; e_rd = 0; e_ra = 0;
    end
  endtask

  task automatic tick(output bit took);
    @(negedge clk);
    if (live) begin
      chk("fwd", {fwd_valid, fwd_kind, fwd_mask, fwd_mc, fwd_req},
                 {e_fv, e_fk, e_fm, e_fmc, e_fq});
      chk("rsp", {rsp_valid, rsp_kind, rsp_dst, rsp_acks}, {e_rv, e_rk, e_rd, e_ra});
    end
    req_valid = d_rv; req_kind = 3'(d_rk); req_src = IDW'(d_rs);
    data_valid = d_dv; mc_ack = d_ack;
    #1;
    if (live) chk("req_ready", req_ready, m_ready(d_rk));
    model_step(took);
  endtask

  task automatic idle(int n);
    bit t;
    for (int i = 0; i < n; i++) tick(t);
  endtask

  task automatic request(int k, int s);
    bit t = 0;
    d_rv = 1; d_rk = k; d_rs = s;
    for (int i = 0; i < 50 && !t; i++) tick(t);
    d_rv = 0;
    if (!t) begin n_fail++; $display("FAIL %s request %0d never accepted: actual 0 expected 1", tag, k); end
    idle(1);
  endtask

  task automatic hold_request(int k, int s, int n);
    bit t;
    d_rv = 1; d_rk = k; d_rs = s;
    for (int i = 0; i < n; i++) begin
      tick(t);
      chk("stalled request taken", t, 0);
    end
  endtask

  task automatic pulse_data();
    bit t;
    d_dv = 1; tick(t); d_dv = 0; idle(1);
  endtask

  task automatic pulse_ack();
    bit t;
    d_ack = 1; tick(t); d_ack = 0;
  endtask

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; req_src = 0; data_valid = 0; mc_ack = 0;
    d_rv = 0; d_rk = 0; d_rs = 0; d_dv = 0; d_ack = 0;
    m_st = 0; m_sh = 0; m_own = 0; m_pend = 0;
    e_fv = 0; e_fk = 0; e_fm = 0; e_fmc = 0; e_fq = 0; e_rv = 0; e_rk = 0; e_rd = 0; e_ra = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #1;
    tag = "R1";
    chk("reset fwd_valid", fwd_valid, 0);
    chk("reset rsp_valid", rsp_valid, 0);
    chk("reset req_ready", req_ready, 1);
    live = 1;

    tag = "R6";
    request(2, 1); request(3, 2); request(4, 0); idle(2);

    tag = "R2";
    request(0, 0);
    hold_request(0, 1, 3);
    d_rv = 0;
    pulse_data();
    request(0, 1);

    tag = "R3";
    request(1, 2);

    tag = "R8";
    request(0, 3);
    pulse_data();

    tag = "R9";
    request(2, 2); request(2, 3);
    request(0, 1);
    tag = "R3";
    request(1, 1);

    tag = "R4";
    request(4, 0);
    hold_request(0, 0, 4);
    pulse_ack();
    request(0, 0);
    pulse_data();

    tag = "R7";
    request(1, 3);
    request(4, 0);
    request(3, 3);
    request(2, 1);
    idle(2);
    pulse_ack();
    idle(1);

    tag = "R5";
    request(0, 2); pulse_data();
    request(0, 1);
    request(4, 0);
    request(2, 1);
    hold_request(1, 0, 3);
    pulse_ack();

    tag = "R12";
    request(1, 0);
    pulse_data();

    tag = "R11";
    request(1, 1);
    request(3, 1);

    tag = "R10";
    request(4, 0);
    hold_request(4, 0, 3);
    d_rv = 0;
    pulse_ack();
    request(0, 2);
    pulse_data();
    idle(3);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule